// File: doc/BRIEF.md
# Indirect Register Port for an 8-bit Asynchronous Host

This block connects an 8-bit asynchronous microprocessor bus to a bank of write-only control registers. The host never addresses a control register directly. It first loads an internal pointer by writing the address register. Each following data access then lands on the register that the pointer selects, and the pointer steps forward by one. The only thing a host can read is a status byte, which comes back when it reads the address register.

All bus controls are asynchronous to the local clock. They pass through a synchronizer, and an access starts when the synchronized chip select falls. The block tells the host that an access has finished by pulling an open-drain acknowledge line LOW. The line is released again after chip select goes HIGH. An active-LOW reset does three things: it cancels any access in progress, it releases both the data bus and the acknowledge line, and it reloads four registers with fixed values. Every other register keeps its contents through reset. The full register bank is presented as one flat vector so that the functions being controlled can use it.

Top module: `mpu_regport`

## Requirements
- R1: `rw` LOW makes the cycle a write and `rw` HIGH makes it a read. `rs` LOW selects the address register and `rs` HIGH selects the data register.
- R2: A write to the address register loads the pointer from `db` and changes no control register.
- R3: A data write stores `db` into register number *pointer*, which appears at `ctrl_regs[8*p+7:8*p]`. Every data access, read or write, then increments the pointer, and the pointer wraps from FFh to 00h.
- R4: A read of the address register drives `db` with the `status_in` value captured when the access is recognised, and the bus stays driven until the cycle ends. A data read leaves `db` undriven and changes no register.
- R5: `ack_n` is driven LOW from the 4th rising clock edge after `cs_n` falls. It is released to high impedance on the 3rd rising edge after `cs_n` returns HIGH, and it is high impedance at all other times.
- R6: While `rst_n` is LOW, both `ack_n` and `db` are released and the pointer clears to 00h. An access that reset interrupts has no effect, and a new access needs `cs_n` to be seen HIGH after reset.
- R7: Reset loads register 3Ah with 1Fh, register 61h with 06h, and registers 6Ch and 7Ah with 00h. All other registers keep their values.
- R8: `cs_n`, `rw`, `rs` and `db` each pass through a two-flop synchronizer. An access is recognised only on a HIGH-to-LOW transition of the synchronized chip select, so holding `cs_n` LOW performs exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous reset, active LOW |
| cs_n | input | 1 | Chip select, active LOW |
| rw | input | 1 | Cycle direction: LOW write, HIGH read |
| rs | input | 1 | Register select: LOW address, HIGH data |
| db | inout | 8 | Bidirectional data bus |
| ack_n | output | 1 | Acknowledge, driven LOW or high impedance |
| status_in | input | 8 | Status byte returned on address reads |
| ctrl_regs | output | 2048 | All control registers, register n in bits 8n+7..8n |

## Verification
From the falling edge of `cs_n`, three rising edges pass before a register is written or the status is captured (two synchronizer stages and one access edge), and the acknowledge follows on the fourth edge. The release comes three edges after `cs_n` rises. The bench drives every input on a falling clock edge. It counts falling edges from the change of `cs_n`: it reads `ack_n` one edge before it is due and again on the edge it is due, and it reads the register outputs and the captured status only after the access edge has passed. To show that the status byte is sampled rather than passed through, the bench changes `status_in` just after the capture edge and checks the value that appears on the bus.

// File: rtl/mpu_regport_pkg.sv
package mpu_regport_pkg;

   typedef enum logic [1:0] {
      BUS_IDLE = 2'd0,
      BUS_DONE = 2'd1,
      BUS_ACK  = 2'd2
   } bus_state_e;

   // Registers that reset reloads, with their reload values
   localparam int unsigned DFLT_ADDR_0 = 32'h3A;
   localparam int unsigned DFLT_ADDR_1 = 32'h61;
   localparam int unsigned DFLT_ADDR_2 = 32'h6C;
   localparam int unsigned DFLT_ADDR_3 = 32'h7A;
   localparam logic [7:0]  DFLT_VAL_0  = 8'h1F;
   localparam logic [7:0]  DFLT_VAL_1  = 8'h06;
   localparam logic [7:0]  DFLT_VAL_2  = 8'h00;
   localparam logic [7:0]  DFLT_VAL_3  = 8'h00;

   // Smallest pointer width that still reaches every reloaded register
   localparam int unsigned MIN_ADDR_W  = 7;

   function automatic logic has_default(input int unsigned idx);
      return (idx == DFLT_ADDR_0) || (idx == DFLT_ADDR_1) ||
             (idx == DFLT_ADDR_2) || (idx == DFLT_ADDR_3);
   endfunction

   function automatic logic [7:0] default_value(input int unsigned idx);
      logic [7:0] v;
      v = 8'h00;
      if (idx == DFLT_ADDR_0) v = DFLT_VAL_0;
      if (idx == DFLT_ADDR_1) v = DFLT_VAL_1;
      if (idx == DFLT_ADDR_2) v = DFLT_VAL_2;
      if (idx == DFLT_ADDR_3) v = DFLT_VAL_3;
      return v;
   endfunction

endpackage

// File: rtl/mpu_sync.sv
module mpu_sync #(
   parameter int unsigned     WIDTH   = 1,
   parameter int unsigned     STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mpu_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("mpu_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/mpu_bus_ctrl.sv
module mpu_bus_ctrl
   import mpu_regport_pkg::*;
#(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_s,
   input  logic          rw_s,
   input  logic          rs_s,
   input  logic [DW-1:0] d_s,
   input  logic [DW-1:0] status_in,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          bus_oe,
   output logic [DW-1:0] rd_data,
   output logic          ack_on
);

   generate
      if (AW > DW) begin : g_bad_aw
         $error("mpu_bus_ctrl: pointer wider than the data bus");
      end
   endgenerate

   bus_state_e    state_q;
   logic          cs_prev_q;
   logic [AW-1:0] ptr_q;
   logic [DW-1:0] rd_q;
   logic          oe_q;
   logic          start;

   // An access begins on a synchronized HIGH-to-LOW chip select
   assign start   = (state_q == BUS_IDLE) && cs_prev_q && !cs_s;
   assign wr_en   = start && !rw_s && rs_s;
   assign wr_addr = ptr_q;
   assign wr_data = d_s;
   assign bus_oe  = oe_q;
   assign rd_data = rd_q;
   assign ack_on  = (state_q == BUS_ACK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev_q <= 1'b0;
      end else begin
         cs_prev_q <= cs_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BUS_IDLE;
         ptr_q   <= '0;
         rd_q    <= '0;
         oe_q    <= 1'b0;
      end else begin
         unique case (state_q)
            BUS_IDLE: begin
               if (start) begin
                  state_q <= BUS_DONE;
                  if (rs_s) begin
                     ptr_q <= ptr_q + 1'b1;
                  end else if (!rw_s) begin
                     ptr_q <= d_s[AW-1:0];
                  end else begin
                     rd_q <= status_in;
                     oe_q <= 1'b1;
                  end
               end
            end
            BUS_DONE: begin
               state_q <= BUS_ACK;
            end
            BUS_ACK: begin
               if (cs_s) begin
                  state_q <= BUS_IDLE;
                  oe_q    <= 1'b0;
               end
            end
            default: begin
               state_q <= BUS_IDLE;
               oe_q    <= 1'b0;
            end
         endcase
      end
   end

   // R3
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && rs_s) |=> (ptr_q == $past(ptr_q) + 1'b1));

   // R2
   ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !rs_s && !rw_s) |=> (ptr_q == $past(d_s[AW-1:0])));

   // R5
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_on && !cs_s) |=> ack_on);

   // R5
   ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !ack_on);

   // R4
   drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> (state_q != BUS_IDLE));

endmodule

// File: rtl/mpu_regfile.sv
module mpu_regfile
   import mpu_regport_pkg::*;
#(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 8,
   localparam int unsigned NREG = 2 ** AW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [DW-1:0]      wr_data,
   output logic [NREG*DW-1:0] regs_flat
);

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         logic [DW-1:0] q;
         if (has_default(i)) begin : g_reload
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  q <= DW'(default_value(i));
               end else if (wr_en && (wr_addr == AW'(i))) begin
                  q <= wr_data;
               end
            end
         end else begin : g_keep
            always_ff @(posedge clk) begin
               if (wr_en && (wr_addr == AW'(i))) begin
                  q <= wr_data;
               end
            end
         end
         assign regs_flat[i*DW +: DW] = q;
      end
   endgenerate

   // R3
   store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (regs_flat[$past(wr_addr)*DW +: DW] == $past(wr_data)));

   // R7
   reload_chk: assert property (@(posedge clk)
      !rst_n |=> ((regs_flat[DFLT_ADDR_0*DW +: DW] == DW'(DFLT_VAL_0)) &&
                  (regs_flat[DFLT_ADDR_1*DW +: DW] == DW'(DFLT_VAL_1)) &&
                  (regs_flat[DFLT_ADDR_2*DW +: DW] == DW'(DFLT_VAL_2)) &&
                  (regs_flat[DFLT_ADDR_3*DW +: DW] == DW'(DFLT_VAL_3))));

endmodule

// File: rtl/mpu_regport.sv
module mpu_regport
   import mpu_regport_pkg::*;
#(
   parameter int unsigned AW          = 8,
   parameter int unsigned DW          = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NREG       = 2 ** AW,
   localparam int unsigned REG_BITS   = NREG * DW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                rw,
   input  logic                rs,
   inout  wire  [DW-1:0]       db,
   output wire                 ack_n,
   input  logic [DW-1:0]       status_in,
   output logic [REG_BITS-1:0] ctrl_regs
);

   localparam int unsigned SYNC_W = DW + 3;

   generate
      if (AW < MIN_ADDR_W) begin : g_bad_aw
         $error("mpu_regport: AW too small for the reloaded registers");
      end
      if (DW < 8) begin : g_bad_dw
         $error("mpu_regport: DW must be at least 8");
      end
      if (AW > DW) begin : g_bad_ratio
         $error("mpu_regport: AW must not exceed DW");
      end
   endgenerate

   logic [SYNC_W-1:0] sync_q;
   logic              cs_s, rw_s, rs_s;
   logic [DW-1:0]     d_s;
   logic              wr_en, bus_oe, ack_on;
   logic [AW-1:0]     wr_addr;
   logic [DW-1:0]     wr_data, rd_data;

   // Synchronizer resets to zero: chip select reads as asserted,
   // so a fresh HIGH must be seen before any access
   mpu_sync #(
      .WIDTH   (SYNC_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ('0)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, rw, rs, db}),
      .q     (sync_q)
   );

   assign {cs_s, rw_s, rs_s, d_s} = sync_q;

   mpu_bus_ctrl #(
      .AW (AW),
      .DW (DW)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_s      (cs_s),
      .rw_s      (rw_s),
      .rs_s      (rs_s),
      .d_s       (d_s),
      .status_in (status_in),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .bus_oe    (bus_oe),
      .rd_data   (rd_data),
      .ack_on    (ack_on)
   );

   mpu_regfile #(
      .AW (AW),
      .DW (DW)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .regs_flat (ctrl_regs)
   );

   assign db    = bus_oe ? rd_data : {DW{1'bz}};
   assign ack_n = ack_on ? 1'b0 : 1'bz;

   // R6
   quiet_in_reset_chk: assert property (@(posedge clk)
      !rst_n |-> (!bus_oe && !ack_on));

   // R4
   no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_oe) |-> ($past(rw_s) && !$past(rs_s)));

endmodule

// File: tb/tb_mpu_regport.sv
`timescale 1ns/1ps
module tb_mpu_regport;

   localparam int NREG = 256;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       rw = 1'b1;
   logic       rs = 1'b0;
   logic [7:0] tb_d = 8'h00;
   logic       tb_oe = 1'b0;
   logic [7:0] status_in = 8'h00;
   wire  [7:0] db;
   wire        ack_n;
   wire  [NREG*8-1:0] ctrl_regs;

   int checks = 0;
   int fails  = 0;

   assign db = tb_oe ? tb_d : 8'bz;
   pullup (ack_n);
   for (genvar b = 0; b < 8; b++) begin : g_pu
      pullup (db[b]);
   end

   mpu_regport dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .rw        (rw),
      .rs        (rs),
      .db        (db),
      .ack_n     (ack_n),
      .status_in (status_in),
      .ctrl_regs (ctrl_regs)
   );

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 37 + 5) & 255);
   endfunction

   function automatic logic [7:0] reg_at(input int i);
      return ctrl_regs[i*8 +: 8];
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One full bus cycle with acknowledge timing checks (R5, R1)
   task automatic bus_cycle(input logic r, input logic sel, input logic [7:0] d,
                            input logic [7:0] st_late, output logic [7:0] seen);
      @(negedge clk);
      rw = r; rs = sel; tb_d = d; tb_oe = ~r;
      @(negedge clk);
      cs_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R5 ack not before 4th edge", ack_n, 1);
      status_in = st_late;
      @(negedge clk);
      check("R5 ack low on 4th edge", ack_n, 0);
      seen = db;
      cs_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R5 ack held until release", ack_n, 0);
      @(negedge clk);
      check("R5 ack released", ack_n, 1);
      tb_oe = 1'b0;
   endtask

   task automatic wr_addr(input logic [7:0] a);
      logic [7:0] s;
      bus_cycle(1'b0, 1'b0, a, status_in, s);
   endtask

   task automatic wr_data(input logic [7:0] d);
      logic [7:0] s;
      bus_cycle(1'b0, 1'b1, d, status_in, s);
   endtask

   task automatic check_defaults(input string tag);
      check({tag, " R7 reg 3A"}, reg_at(8'h3A), 8'h1F);
      check({tag, " R7 reg 61"}, reg_at(8'h61), 8'h06);
      check({tag, " R7 reg 6C"}, reg_at(8'h6C), 8'h00);
      check({tag, " R7 reg 7A"}, reg_at(8'h7A), 8'h00);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [7:0] seen;
      // Reset state (R6, R7)
      repeat (4) @(negedge clk);
      check("R6 ack released in reset", ack_n, 1);
      check("R6 bus released in reset", db, 8'hFF);
      check_defaults("reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Fill the whole bank through one pointer load (R1, R2, R3)
      wr_addr(8'h00);
      for (int i = 0; i < NREG; i++) wr_data(pat(i));
      for (int i = 0; i < NREG; i++) check("R3 sweep register", reg_at(i), pat(i));

      // Pointer wrap FF -> 00 (R3)
      wr_addr(8'hFE);
      wr_data(8'h11);
      wr_data(8'h22);
      wr_data(8'h33);
      wr_data(8'h44);
      check("R3 wrap FE", reg_at(8'hFE), 8'h11);
      check("R3 wrap FF", reg_at(8'hFF), 8'h22);
      check("R3 wrap 00", reg_at(8'h00), 8'h33);
      check("R3 wrap 01", reg_at(8'h01), 8'h44);

      // Status read sampled at start, pointer untouched (R4, R1)
      status_in = 8'hA5;
      bus_cycle(1'b1, 1'b0, 8'h00, 8'h3C, seen);
      check("R4 status byte sampled at start", seen, 8'hA5);
      wr_data(8'h55);
      check("R4 status read leaves pointer", reg_at(8'h02), 8'h55);

      // Data read: no drive, no store, pointer advances (R4, R3)
      status_in = 8'h5A;
      bus_cycle(1'b1, 1'b1, 8'h00, 8'h5A, seen);
      check("R4 data read leaves bus undriven", seen, 8'hFF);
      check("R4 data read changes no register", reg_at(8'h03), pat(3));
      wr_data(8'h66);
      check("R3 data read advanced pointer", reg_at(8'h04), 8'h66);

      // Address write stores nothing (R2)
      wr_addr(8'h10);
      check("R2 address write stores nothing", reg_at(8'h10), pat(16));
      wr_data(8'h77);
      check("R2 pointer loaded from bus", reg_at(8'h10), 8'h77);

      // Chip select held low: exactly one access (R8)
      wr_addr(8'h30);
      @(negedge clk);
      rw = 1'b0; rs = 1'b1; tb_d = 8'h9C; tb_oe = 1'b1;
      @(negedge clk);
      cs_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R8 no store before synchronizer delay", reg_at(8'h30), pat(8'h30));
      @(negedge clk);
      check("R8 store on 3rd edge", reg_at(8'h30), 8'h9C);
      repeat (12) @(negedge clk);
      check("R8 held select no repeat", reg_at(8'h31), pat(8'h31));
      cs_n = 1'b1;
      repeat (4) @(negedge clk);
      tb_oe = 1'b0;

      // Reset in mid-cycle aborts the access (R6, R7)
      wr_addr(8'h40);
      @(negedge clk);
      rw = 1'b0; rs = 1'b1; tb_d = 8'h99; tb_oe = 1'b1;
      @(negedge clk);
      cs_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R6 ack released during abort", ack_n, 1);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      check("R6 aborted write has no effect", reg_at(8'h40), pat(8'h40));
      check("R6 no access without fresh select", ack_n, 1);
      cs_n = 1'b1;
      repeat (4) @(negedge clk);
      tb_oe = 1'b0;
      check_defaults("abort");
      check("R7 other register keeps value", reg_at(8'h3B), pat(8'h3B));
      check("R7 written register keeps value", reg_at(8'h10), 8'h77);
      wr_data(8'hC3);
      check("R6 pointer cleared by reset", reg_at(8'h00), 8'hC3);

      finish_run();
   end

endmodule